// File: doc/BRIEF.md
# SPI Serial EEPROM Command Interface

This block is the serial-facing control logic of a small SPI EEPROM. It receives chip select, serial clock, serial data and a pause input from an external host. The host clock is asynchronous to the block, so all four are brought into the system clock domain before their edges are detected. The block decodes an 8-bit instruction and keeps a write-enable latch. It serves reads from a register-based array and the status byte, and buffers byte or page writes. A write is committed only when the selection ends cleanly, and each committed write starts a timed internal programming interval.

While programming runs, array reads and writes are refused and the serial output stays off. The status byte can still be read, so the host can poll for completion. The host may pause a transfer with the hold input. A pause freezes the shift state and turns the output driver off. The block drives a data bit and a separate enable; the pad-level three-state buffer sits outside.

Top module: `spi_eeprom_ctl`

## Requirements
- R1: When hold falls while the serial clock is low, the transfer pauses. During the pause, sdo_oe is low, and clock and data transitions change neither the bit position nor the shifted data.
- R2: A pause ends only when hold is high while the serial clock is low. Raising hold while the clock is high leaves the output off. After resuming, the transfer continues from the bit where it stopped.
- R3: A falling hold edge while the serial clock is high does not pause the transfer.
- R4: If chip select rises during a pause, the selection is aborted. Any buffered write is dropped and the write-enable latch keeps its value.
- R5: After reset, the write-enable latch and sdo_oe are low. No instruction is accepted until chip select has fallen after reset.
- R6: Opcode 0x06 sets the write-enable latch and 0x04 clears it. The status byte (opcode 0x05) carries write-in-progress in bit 0, the latch in bit 1 and the stored user bits in bits 7:2.
- R7: A write (0x02) or status write (0x01) issued while the latch is clear is ignored.
- R8: A write commits only when chip select rises after one or more whole data bytes. If chip select rises at any other bit count, including right after the address, nothing is stored and the latch is left unchanged.
- R9: A commit clears the latch and holds write-in-progress high for WR_CYCLES clocks. A status write stores data bits 7:2 into status bits 7:2.
- R10: A write (0x02, then a 16-bit address MSB first, then data) stores consecutive bytes. The address wraps inside its PAGE-byte page, and the other pages are left untouched.
- R11: While write-in-progress is high, reads, writes and latch instructions are ignored and sdo_oe stays low. A status read still returns the status byte.
- R12: An unrecognised opcode leaves sdo_oe low until chip select rises. The next selection works normally.
- R13: A read (0x03, then a 16-bit address) samples input bits on the rising clock edge. It shifts data out on the falling edge, MSB first, and continues across page boundaries to the following addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, standing in for power-on reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output driver enable for sdo |

## Verification
The bench builds the block with a 64-byte array of two 32-byte pages and a 2000-clock programming interval. With two pages, a page write that wraps at the top of page 0 can be told apart from a spill into page 1, and a sequential read can cross the page boundary. The interval is longer than a multi-byte command at the bench clock rate. This lets the bench observe write-in-progress, refused reads and refused latch changes while programming is still running.

// File: rtl/spi_eeprom_ctl.sv
module spi_eeprom_ctl #(
  parameter int DEPTH     = 256,
  parameter int PAGE      = 32,
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic hold_n,
  output logic sdo,
  output logic sdo_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_OP, S_AH, S_AL, S_RD, S_RSR, S_WR, S_WSR, S_IGN} st_t;

  logic [1:0] cs_m, sck_m, sdi_m, hold_m;
  logic cs_q, sck_q, hold_q;
  logic active, paused, is_wr, got;
  st_t st;
  logic [2:0] bidx;
  logic [7:0] sr, ahi, obuf;
  logic [AW-1:0] addr;
  logic [AW-PW-1:0] pg;
  logic sdo_r, wel, busy;
  logic [CW-1:0] wcnt;
  logic [5:0] ubits, wsr;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] pmask;

  wire cs_s   = cs_m[1];
  wire sck_s  = sck_m[1];
  wire sdi_s  = sdi_m[1];
  wire hold_s = hold_m[1];

  wire cs_fall   = cs_q & ~cs_s;
  wire cs_rise   = ~cs_q & cs_s;
  wire sck_rise  = ~sck_q & sck_s;
  wire sck_fall  = sck_q & ~sck_s;
  wire hold_fall = hold_q & ~hold_s;

  wire [7:0] nxt    = {sr[6:0], sdi_s};
  wire [AW-1:0] a_new = AW'({ahi, nxt});
  wire [7:0] status = {ubits, wel, busy};
  wire out_ph = (st == S_RD) || (st == S_RSR);
  wire rd_ph  = (st == S_RD);
  wire clean_end = cs_rise & active & ~paused & (bidx == 3'd0) & got;
  wire commit_wr = clean_end & (st == S_WR);
  wire commit_sr = clean_end & (st == S_WSR);

  assign sdo    = sdo_r;
  assign sdo_oe = active & ~paused & out_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_m <= '0; sck_m <= '0; sdi_m <= '0; hold_m <= 2'b11;
      cs_q <= 1'b0; sck_q <= 1'b0; hold_q <= 1'b1;
      active <= 1'b0; paused <= 1'b0; is_wr <= 1'b0; got <= 1'b0;
      st <= S_OP; bidx <= '0; sr <= '0; ahi <= '0; obuf <= '0;
      addr <= '0; pg <= '0; sdo_r <= 1'b0; wel <= 1'b0; busy <= 1'b0;
      wcnt <= '0; ubits <= '0; wsr <= '0; pmask <= '0;
    end else begin
      cs_m   <= {cs_m[0], cs_n};
      sck_m  <= {sck_m[0], sck};
      sdi_m  <= {sdi_m[0], sdi};
      hold_m <= {hold_m[0], hold_n};
      cs_q   <= cs_s;
      sck_q  <= sck_s;
      hold_q <= hold_s;

      if (busy) begin
        wcnt <= wcnt - CW'(1);
        if (wcnt == CW'(1)) busy <= 1'b0;
      end

      if (cs_fall) begin
        active <= 1'b1; paused <= 1'b0; st <= S_OP; bidx <= '0; got <= 1'b0;
      end else if (cs_rise) begin
        active <= 1'b0; paused <= 1'b0; st <= S_OP; bidx <= '0;
        if (commit_wr || commit_sr) begin
          busy <= 1'b1;
          wcnt <= CW'(WR_CYCLES);
          wel  <= 1'b0;
        end
        if (commit_sr) ubits <= wsr;
      end else if (active) begin
        if (paused) begin
          if (hold_s && !sck_s) paused <= 1'b0;
        end else if (hold_fall && !sck_s) begin
          paused <= 1'b1;
        end

        if (!paused && sck_rise && st != S_IGN) begin
          sr   <= nxt;
          bidx <= bidx + 3'd1;
          if (bidx == 3'd7) begin
            case (st)
              S_OP: begin
                case (nxt)
                  8'h06: begin if (!busy) wel <= 1'b1; st <= S_IGN; end
                  8'h04: begin if (!busy) wel <= 1'b0; st <= S_IGN; end
                  8'h05: begin st <= S_RSR; obuf <= status; end
                  8'h01: st <= (wel && !busy) ? S_WSR : S_IGN;
                  8'h03: begin st <= !busy ? S_AH : S_IGN; is_wr <= 1'b0; end
                  8'h02: begin st <= (wel && !busy) ? S_AH : S_IGN; is_wr <= 1'b1; end
                  default: st <= S_IGN;
                endcase
              end
              S_AH: begin ahi <= nxt; st <= S_AL; end
              S_AL: begin
                if (is_wr) begin
                  st    <= S_WR;
                  addr  <= a_new;
                  pg    <= a_new[AW-1:PW];
                  pmask <= '0;
                end else begin
                  st   <= S_RD;
                  obuf <= mem[a_new];
                  addr <= a_new + AW'(1);
                end
              end
              S_RD: begin obuf <= mem[addr]; addr <= addr + AW'(1); end
              S_RSR: obuf <= status;
              S_WR: begin
                pbuf[addr[PW-1:0]]  <= nxt;
                pmask[addr[PW-1:0]] <= 1'b1;
                addr <= {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
                got  <= 1'b1;
              end
              S_WSR: begin wsr <= nxt[7:2]; got <= 1'b1; end
              default: ;
            endcase
          end
        end else if (!paused && sck_fall && out_ph) begin
          sdo_r <= obuf[7];
          obuf  <= {obuf[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_wr) begin
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{pg, PW'(i)}] <= pbuf[i];
    end
  end
endmodule

module spi_eeprom_ctl_chk (
  input logic clk,
  input logic rst,
  input logic sdo_oe,
  input logic active,
  input logic paused,
  input logic sck_s,
  input logic hold_s,
  input logic busy,
  input logic wel,
  input logic rd_ph,
  input logic [2:0] bidx,
  input logic [7:0] sr
);
  AST_PAUSE_HIZ: assert property (@(posedge clk) disable iff (rst)
    paused |-> !sdo_oe); // R1
  AST_PAUSE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (paused && $past(paused)) |-> ($stable(bidx) && $stable(sr))); // R1
  AST_PAUSE_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($fell(paused) && active) |-> $past(hold_s && !sck_s)); // R2
  AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(paused) |-> $past(!sck_s)); // R3
  AST_COMMIT_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel); // R9
  AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(sdo_oe && rd_ph)); // R11
  AST_OE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> active); // R12
endmodule

bind spi_eeprom_ctl spi_eeprom_ctl_chk u_chk (
  .clk(clk), .rst(rst), .sdo_oe(sdo_oe), .active(active), .paused(paused),
  .sck_s(sck_s), .hold_s(hold_s), .busy(busy), .wel(wel), .rd_ph(rd_ph),
  .bidx(bidx), .sr(sr)
);

// File: tb/spi_eeprom_ctl_tb.sv
module spi_eeprom_ctl_tb;
  localparam int DEPTH = 64;
  localparam int PAGE  = 32;
  localparam int WRC   = 2000;
  localparam int HP    = 8;

  logic clk = 0, rst, cs_n, sck, sdi, hold_n;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;
  bit done = 0, cap = 0, oe_any = 0;
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic [7:0] mon_rx;
  int mon_n = 0;

  always #10 clk = ~clk;

  spi_eeprom_ctl #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi), .hold_n(hold_n),
    .sdo(sdo), .sdo_oe(sdo_oe));

  always @(posedge sck) if (cap) begin
    logic [7:0] e;
    string t;
    mon_rx = {mon_rx[6:0], sdo_oe ? sdo : 1'bx};
    mon_n++;
    if (mon_n == 8) begin
      mon_n = 0;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (mon_rx !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, mon_rx, e);
      end
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic sel(); cs_n = 0; tick(HP); endtask
  task automatic desel(); sck = 0; tick(HP); cs_n = 1; tick(2*HP); endtask

  task automatic bit_x(input logic b);
    sdi = b; tick(HP);
    if (sdo_oe) oe_any = 1;
    sck = 1; tick(HP); sck = 0;
  endtask

  task automatic byte_x(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_x(v[i]);
  endtask

  task automatic expect_byte(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    cap = 1; byte_x(8'h00); cap = 0;
  endtask

  task automatic cmd(input logic [7:0] op); sel(); byte_x(op); desel(); endtask

  task automatic rd_status(input logic [7:0] e, input string t);
    sel(); byte_x(8'h05); expect_byte(e, t); desel();
  endtask

  task automatic rd1(input logic [15:0] a, input logic [7:0] e, input string t);
    sel(); byte_x(8'h03); byte_x(a[15:8]); byte_x(a[7:0]); expect_byte(e, t); desel();
  endtask

  task automatic wr1(input logic [15:0] a, input logic [7:0] d);
    sel(); byte_x(8'h02); byte_x(a[15:8]); byte_x(a[7:0]); byte_x(d); desel();
  endtask

  task automatic wait_idle(); tick(WRC + 50); endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cs_n = 0; sck = 0; sdi = 0; hold_n = 1; rst = 1;
    tick(5); rst = 0; tick(4);
    chk(sdo_oe == 0, "R5 output off after reset", {7'd0, sdo_oe}, 8'h00);
    oe_any = 0; byte_x(8'h05); byte_x(8'h00);
    chk(!oe_any, "R5 no instruction before CS falls", {7'd0, oe_any}, 8'h00);
    desel();
    rd_status(8'h00, "R5 latch clear after reset");

    wr1(16'h0008, 8'h66);
    rd1(16'h0008, 8'h00, "R7 write without latch ignored");
    sel(); byte_x(8'h01); byte_x(8'hFC); desel();
    rd_status(8'h00, "R7 status write without latch ignored");

    cmd(8'h06); rd_status(8'h02, "R6 enable sets latch");
    cmd(8'h04); rd_status(8'h00, "R6 disable clears latch");

    cmd(8'h06); wr1(16'h0005, 8'h5A);
    rd_status(8'h01, "R9 busy set and latch cleared");
    wait_idle();
    rd_status(8'h00, "R9 busy ends");
    rd1(16'h0005, 8'h5A, "R9 byte stored");

    cmd(8'h06);
    sel(); byte_x(8'h02); byte_x(8'h00); byte_x(8'h1E);
    byte_x(8'h11); byte_x(8'h22); byte_x(8'h33); byte_x(8'h44); desel();
    wait_idle();
    sel(); byte_x(8'h03); byte_x(8'h00); byte_x(8'h1E);
    expect_byte(8'h11, "R13 sequential read byte 30");
    expect_byte(8'h22, "R13 sequential read byte 31");
    expect_byte(8'h00, "R10 next page untouched");
    desel();
    sel(); byte_x(8'h03); byte_x(8'h00); byte_x(8'h00);
    expect_byte(8'h33, "R10 page wrap byte 0");
    expect_byte(8'h44, "R10 page wrap byte 1");
    desel();

    cmd(8'h06);
    sel(); byte_x(8'h02); byte_x(8'h00); byte_x(8'h08); byte_x(8'h99);
    for (int i = 0; i < 4; i++) bit_x(1'b1);
    desel();
    rd_status(8'h02, "R8 partial byte keeps latch");
    rd1(16'h0008, 8'h00, "R8 partial write discarded");
    sel(); byte_x(8'h02); byte_x(8'h00); byte_x(8'h09); desel();
    rd_status(8'h02, "R8 address only keeps latch");

    wr1(16'h0008, 8'hC3);
    sel(); byte_x(8'h03); byte_x(8'h00); byte_x(8'h05);
    oe_any = 0; byte_x(8'h00); desel();
    chk(!oe_any, "R11 read refused while busy", {7'd0, oe_any}, 8'h00);
    cmd(8'h06);
    rd_status(8'h01, "R11 status readable, enable refused while busy");
    wait_idle();
    rd1(16'h0008, 8'hC3, "R11 programming completed");

    sel(); oe_any = 0; byte_x(8'hAB); byte_x(8'h00); byte_x(8'h00); desel();
    chk(!oe_any, "R12 unknown opcode keeps output off", {7'd0, oe_any}, 8'h00);
    rd_status(8'h00, "R12 next selection works");

    sel(); byte_x(8'h03); byte_x(8'h00); byte_x(8'h05);
    exp_q.push_back(8'h5A); tag_q.push_back("R1 R2 byte intact across pause");
    cap = 1;
    for (int i = 0; i < 3; i++) bit_x(1'b0);
    tick(HP); hold_n = 0; tick(HP);
    chk(sdo_oe == 0, "R1 output off in pause", {7'd0, sdo_oe}, 8'h00);
    cap = 0;
    for (int i = 0; i < 3; i++) begin
      sdi = ~sdi; sck = 1; tick(HP); sck = 0; tick(HP);
    end
    chk(sdo_oe == 0, "R1 clocks ignored in pause", {7'd0, sdo_oe}, 8'h00);
    sck = 1; tick(HP); hold_n = 1; tick(HP);
    chk(sdo_oe == 0, "R2 hold high with clock high keeps pause", {7'd0, sdo_oe}, 8'h00);
    sck = 0; tick(HP);
    chk(sdo_oe == 1, "R2 pause ends with clock low", {7'd0, sdo_oe}, 8'h01);
    cap = 1;
    for (int i = 0; i < 5; i++) bit_x(1'b0);
    cap = 0; desel();

    sel(); byte_x(8'h03); byte_x(8'h00); byte_x(8'h05);
    exp_q.push_back(8'h5A); tag_q.push_back("R3 byte intact");
    cap = 1;
    for (int i = 0; i < 2; i++) bit_x(1'b0);
    sdi = 0; tick(HP); sck = 1; tick(HP/2); hold_n = 0; tick(HP/2); sck = 0; tick(HP);
    chk(sdo_oe == 1, "R3 hold fall with clock high ignored", {7'd0, sdo_oe}, 8'h01);
    for (int i = 0; i < 5; i++) bit_x(1'b0);
    cap = 0; hold_n = 1; desel();

    cmd(8'h06);
    sel(); byte_x(8'h02); byte_x(8'h00); byte_x(8'h10); byte_x(8'h77);
    tick(HP); hold_n = 0; tick(HP); cs_n = 1; tick(HP); hold_n = 1; tick(2*HP);
    rd_status(8'h02, "R4 abort keeps latch");
    rd1(16'h0010, 8'h00, "R4 aborted write not stored");

    sel(); byte_x(8'h01); byte_x(8'hFC); desel();
    rd_status(8'hFD, "R9 status write busy, latch cleared");
    wait_idle();
    rd_status(8'hFC, "R9 status bits stored");

    done = 1;
    summary();
    $finish;
  end
endmodule